// File: doc/BRIEF.md
# Sectioned GPIO Controller with Interrupts

This block controls 32 general-purpose pins through a small memory-mapped register space. The pins are split into four identical sections of eight, and each section answers in its own 64-byte address window. In that window software sets pin direction and drive values and reads back the synchronised pad levels. It also manages per-pin interrupts: a raw status, an enable mask, a masked view of the status, and a choice of edge or level sensing for each pin.

Writes are taken on the rising clock edge when the write strobe is high. Reads are combinational from the address. Pad inputs pass through a two-flop synchroniser before any other logic sees them. One interrupt line, the OR of every unmasked pending bit, signals the processor.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: Pin n sits at bit (n mod 8) of section (n div 8). Section s decodes addresses 0x40*s to 0x40*s+0x3F; address bits 7:6 pick the section and bits 5:0 the offset. A write to one section leaves the registers of the others unchanged.
- R2: After reset, direction reads 0xFF (all inputs), output reads 0, mask reads 0xFF, raw status reads 0, level select reads 0, pad_oe is 0 and irq is 0.
- R3: Offset 0x10 is direction, where 1 means input; pad_oe for a pin is the inverse of its direction bit. Offset 0x14 holds the drive values, is read/write, and appears on pad_out.
- R4: Offset 0x18 reads the pad levels after the two-flop synchroniser: a pad change set up before one clock edge reads back after the second edge. Writes to 0x18 have no effect.
- R5: For a pin in edge mode, a rising synchronised input sets its raw status bit (offset 0x04) on the third clock edge after the pad change. A falling input does not change the status.
- R6: Writing to offset 0x04 clears each status bit written with 1 and leaves bits written with 0 unchanged.
- R7: Offset 0x08 reads the mask; writing ones there sets mask bits (interrupt disabled). Writing ones to offset 0x0C clears mask bits (interrupt enabled). 0x0C reads 0.
- R8: Offset 0x00 reads raw status AND NOT mask. It is read-only, and a write there changes no status bit.
- R9: Offset 0x20 selects level mode per pin (1 = level). A level-mode pin's status bit is set on every cycle its synchronised input is high, so a clear written then has no effect. Once the input is low, the bit stays set until it is cleared.
- R10: irq is high exactly when any section has a masked status bit set.
- R11: Offsets 0x1C, 0x24 to 0x3F and the write-only 0x0C read zero, and read-data bits 31:8 are always zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Byte address: section in bits 7:6, offset in bits 5:0 |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data; bits 7:0 used |
| bus_rdata | output | 32 | Read data for bus_addr |
| pad_in | input | 32 | Pad input levels |
| pad_out | output | 32 | Pad drive values |
| pad_oe | output | 32 | Pad output enables, 1 = drive |
| irq | output | 1 | Combined interrupt request |

## Verification
A table of register writes and readbacks runs on idle pads. It shows that reset values, section decoding and the set/clear mask addresses behave as expected, and that unused and write-only offsets read zero. A multi-section pad pattern (0x12345678) shows that each section sees only its own byte, and it gives a masked status that differs from the raw one. A single rising pin is read on the second and then the third edge to pin down the synchroniser latency, and a falling pin shows that edge mode ignores falling transitions. A level-mode pin is held high while its status is cleared, then released, to separate level behaviour from edge behaviour.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
   localparam int OFS_W = 6;
   localparam logic [OFS_W-1:0] OFS_MSTAT = 6'h00;
   localparam logic [OFS_W-1:0] OFS_STAT  = 6'h04;
   localparam logic [OFS_W-1:0] OFS_MSET  = 6'h08;
   localparam logic [OFS_W-1:0] OFS_MCLR  = 6'h0C;
   localparam logic [OFS_W-1:0] OFS_DIR   = 6'h10;
   localparam logic [OFS_W-1:0] OFS_OUT   = 6'h14;
   localparam logic [OFS_W-1:0] OFS_IN    = 6'h18;
   localparam logic [OFS_W-1:0] OFS_LVL   = 6'h20;

   function automatic logic ofs_readable(input logic [OFS_W-1:0] o);
      return (o == OFS_MSTAT) || (o == OFS_STAT) || (o == OFS_MSET) ||
             (o == OFS_DIR) || (o == OFS_OUT) || (o == OFS_IN) || (o == OFS_LVL);
   endfunction
endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_bank_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_w
      $error("gpio_bank_sync: W must be positive");
   end

   logic [W-1:0] stg [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      stg[i] <= '0;
         else if (i == 0) stg[i] <= d;
         else             stg[i] <= stg[(i > 0) ? i-1 : 0];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_bank_sect.sv
module gpio_bank_sect
   import gpio_bank_pkg::*;
#(
   parameter int PINS        = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [OFS_W-1:0] ofs,
   input  logic [PINS-1:0]  wdata,
   input  logic [PINS-1:0]  pad_i,
   output logic [PINS-1:0]  out_o,
   output logic [PINS-1:0]  oe_o,
   output logic [PINS-1:0]  rdata,
   output logic             irq_o
);
   logic [PINS-1:0] dir_q, out_q, mask_q, stat_q, lvl_q, prev_q;
   logic [PINS-1:0] in_s, rise, lvl_hold, set_ev, clr_v, masked;

   gpio_bank_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (pad_i),
      .q    (in_s)
   );

   assign rise     = in_s & ~prev_q & ~lvl_q;
   assign lvl_hold = in_s & lvl_q;
   assign set_ev   = rise | lvl_hold;
   assign clr_v    = (wr_en && ofs == OFS_STAT) ? wdata : '0;
   assign masked   = stat_q & ~mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q  <= '1;
         out_q  <= '0;
         mask_q <= '1;
         lvl_q  <= '0;
         stat_q <= '0;
         prev_q <= '0;
      end else begin
         prev_q <= in_s;
         stat_q <= (stat_q & ~clr_v) | set_ev;
         if (wr_en) begin
            case (ofs)
               OFS_DIR:  dir_q  <= wdata;
               OFS_OUT:  out_q  <= wdata;
               OFS_MSET: mask_q <= mask_q | wdata;
               OFS_MCLR: mask_q <= mask_q & ~wdata;
               OFS_LVL:  lvl_q  <= wdata;
               default:  ;
            endcase
         end
      end
   end

   always_comb begin
      case (ofs)
         OFS_MSTAT: rdata = masked;
         OFS_STAT:  rdata = stat_q;
         OFS_MSET:  rdata = mask_q;
         OFS_DIR:   rdata = dir_q;
         OFS_OUT:   rdata = out_q;
         OFS_IN:    rdata = in_s;
         OFS_LVL:   rdata = lvl_q;
         default:   rdata = '0;
      endcase
   end

   assign out_o = out_q;
   assign oe_o  = ~dir_q;
   assign irq_o = |masked;

   assert_mask_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && ofs == OFS_MSET) |=> ((mask_q & $past(wdata)) == $past(wdata)));
   assert_mask_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && ofs == OFS_MCLR) |=> ((mask_q & $past(wdata)) == '0));
   assert_w1c_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && ofs == OFS_STAT) |=> ((stat_q & $past(wdata & ~set_ev)) == '0));
   assert_edge_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (|rise) |=> ((stat_q & $past(rise)) == $past(rise)));
   assert_level_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (|lvl_hold) |=> ((stat_q & $past(lvl_hold)) == $past(lvl_hold)));
   assert_no_spurious_R5: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(set_ev)) == '0));
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
   import gpio_bank_pkg::*;
#(
   parameter int NUM_SEC     = 4,
   parameter int SEC_PINS    = 8,
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [ADDR_W-1:0]            bus_addr,
   input  logic                         bus_wr,
   input  logic [DATA_W-1:0]            bus_wdata,
   output logic [DATA_W-1:0]            bus_rdata,
   input  logic [NUM_SEC*SEC_PINS-1:0]  pad_in,
   output logic [NUM_SEC*SEC_PINS-1:0]  pad_out,
   output logic [NUM_SEC*SEC_PINS-1:0]  pad_oe,
   output logic                         irq
);
   localparam int SEL_W = (NUM_SEC > 1) ? $clog2(NUM_SEC) : 1;

   if (ADDR_W != OFS_W + SEL_W) begin : g_bad_addr
      $error("gpio_bank_ctrl: ADDR_W must equal offset width plus section select width");
   end
   if (SEC_PINS > DATA_W || SEC_PINS < 1) begin : g_bad_pins
      $error("gpio_bank_ctrl: SEC_PINS must lie in 1..DATA_W");
   end
   if ((1 << SEL_W) != NUM_SEC) begin : g_bad_sec
      $error("gpio_bank_ctrl: NUM_SEC must be a power of two, at least 2");
   end

   logic [SEL_W-1:0]    sec_idx;
   logic [OFS_W-1:0]    ofs;
   logic [SEC_PINS-1:0] sec_rd  [NUM_SEC];
   logic [NUM_SEC-1:0]  sec_irq;

   assign sec_idx = bus_addr[ADDR_W-1:OFS_W];
   assign ofs     = bus_addr[OFS_W-1:0];

   for (genvar s = 0; s < NUM_SEC; s++) begin : g_sect
      gpio_bank_sect #(.PINS(SEC_PINS), .SYNC_STAGES(SYNC_STAGES)) u_sect (
         .clk  (clk),
         .rst_n(rst_n),
         .wr_en(bus_wr && (sec_idx == SEL_W'(s))),
         .ofs  (ofs),
         .wdata(bus_wdata[SEC_PINS-1:0]),
         .pad_i(pad_in[s*SEC_PINS +: SEC_PINS]),
         .out_o(pad_out[s*SEC_PINS +: SEC_PINS]),
         .oe_o (pad_oe[s*SEC_PINS +: SEC_PINS]),
         .rdata(sec_rd[s]),
         .irq_o(sec_irq[s])
      );
   end

   if (SEC_PINS < DATA_W) begin : g_wide
      logic unused_wdata_hi;
      assign unused_wdata_hi = ^bus_wdata[DATA_W-1:SEC_PINS];
      assign bus_rdata = {{(DATA_W-SEC_PINS){1'b0}}, sec_rd[sec_idx]};
   end else begin : g_full
      assign bus_rdata = sec_rd[sec_idx];
   end

   assign irq = |sec_irq;

   assert_unused_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !ofs_readable(ofs) |-> (bus_rdata == '0));
   assert_rdata_hi_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rdata >> SEC_PINS) == '0);
endmodule

// File: tb/gpio_bank_ctrl_tb.sv
module gpio_bank_ctrl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [31:0] pad_in = '0;
   logic [31:0] pad_out, pad_oe;
   logic        irq;
   int          n_chk = 0;
   int          n_fail = 0;

   always #10 clk = ~clk;

   gpio_bank_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
      .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
   );

   // entry: {req[3:0], is_write, addr[7:0], data[31:0]}; data is write value or expected read
   localparam int NV = 22;
   localparam logic [44:0] VEC [NV] = '{
      {4'd2,  1'b0, 8'h10, 32'h0000_00FF},  // R2 direction reset
      {4'd2,  1'b0, 8'h14, 32'h0000_0000},  // R2 output reset
      {4'd2,  1'b0, 8'h08, 32'h0000_00FF},  // R2 mask reset
      {4'd2,  1'b0, 8'h04, 32'h0000_0000},  // R2 status reset
      {4'd2,  1'b0, 8'h20, 32'h0000_0000},  // R2 level reset
      {4'd3,  1'b1, 8'h54, 32'hFFFF_FFA5},  // R3 section 1 output
      {4'd3,  1'b0, 8'h54, 32'h0000_00A5},  // R3 readback, upper bits dropped (R11)
      {4'd1,  1'b0, 8'h14, 32'h0000_0000},  // R1 section 0 untouched
      {4'd3,  1'b1, 8'h50, 32'h0000_000F},  // R3 section 1 direction
      {4'd3,  1'b0, 8'h50, 32'h0000_000F},
      {4'd7,  1'b1, 8'h8C, 32'h0000_003C},  // R7 clear mask bits
      {4'd7,  1'b0, 8'h88, 32'h0000_00C3},
      {4'd7,  1'b1, 8'h88, 32'h0000_0004},  // R7 set mask bit
      {4'd7,  1'b0, 8'h88, 32'h0000_00C7},
      {4'd11, 1'b0, 8'h8C, 32'h0000_0000},  // R11 write-only reads zero
      {4'd11, 1'b0, 8'h1C, 32'h0000_0000},  // R11 unused offset
      {4'd11, 1'b0, 8'h3C, 32'h0000_0000},  // R11 unused offset
      {4'd9,  1'b1, 8'hE0, 32'h0000_0081},  // R9 level select section 3
      {4'd9,  1'b0, 8'hE0, 32'h0000_0081},
      {4'd4,  1'b1, 8'hD8, 32'h0000_00FF},  // R4 write to input ignored
      {4'd4,  1'b0, 8'hD8, 32'h0000_0000},
      {4'd1,  1'b0, 8'hA0, 32'h0000_0000}   // R1 section 2 level untouched
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wr = 1'b0;
      #2 d = bus_rdata;
   endtask

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
   endtask

   task automatic rdchk(input string req, input logic [7:0] a, input logic [31:0] exp);
      logic [31:0] d;
      rd(a, d);
      chk(req, d, exp);
   endtask

   initial begin
      #(20 * 200000);
      n_chk++; n_fail++;
      $display("FAIL watchdog (all) actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      tick(3);
      @(negedge clk) rst_n = 1'b1;
      #2;
      chk("R2 irq", {31'd0, irq}, 32'd0);
      chk("R2 pad_oe", pad_oe, 32'h0);
      chk("R2 pad_out", pad_out, 32'h0);

      for (int i = 0; i < NV; i++) begin
         if (VEC[i][40]) wr(VEC[i][39:32], VEC[i][31:0]);
         else rdchk($sformatf("R%0d vec%0d", VEC[i][44:41], i), VEC[i][39:32], VEC[i][31:0]);
      end
      chk("R1 R3 pad_out", pad_out, 32'h0000_A500);
      chk("R1 R3 pad_oe", pad_oe, 32'h0000_F000);

      // R4 synchronised input per section
      @(negedge clk) pad_in = 32'h1234_5678;
      tick(2);
      rdchk("R4 sec0 in", 8'h18, 32'h78);
      rdchk("R4 sec1 in", 8'h58, 32'h56);
      rdchk("R4 sec2 in", 8'h98, 32'h34);
      rdchk("R4 sec3 in", 8'hD8, 32'h12);
      tick(3);
      rdchk("R5 sec0 stat", 8'h04, 32'h78);
      rdchk("R5 sec1 stat", 8'h44, 32'h56);
      rdchk("R8 sec0 masked", 8'h00, 32'h00);
      rdchk("R8 sec2 masked", 8'h80, 32'h30);
      chk("R10 irq set", {31'd0, irq}, 32'd1);
      wr(8'h04, 32'hFF); wr(8'h44, 32'hFF); wr(8'h84, 32'hFF); wr(8'hC4, 32'hFF);
      rdchk("R6 sec2 cleared", 8'h84, 32'h00);
      chk("R10 irq clear", {31'd0, irq}, 32'd0);

      // R5 latency and falling edge
      @(negedge clk) pad_in[0] = 1'b1;
      tick(2);
      rdchk("R5 second edge", 8'h04, 32'h00);
      rdchk("R5 third edge", 8'h04, 32'h01);
      @(negedge clk) pad_in[0] = 1'b0;
      tick(4);
      rdchk("R5 falling ignored", 8'h04, 32'h01);
      wr(8'h04, 32'h00);
      rdchk("R6 zero write", 8'h04, 32'h01);
      wr(8'h04, 32'hFE);
      rdchk("R6 other bits", 8'h04, 32'h01);
      wr(8'h04, 32'h01);
      rdchk("R6 clear", 8'h04, 32'h00);

      // R9 level mode on section 3 pin 0 (pad 24)
      @(negedge clk) pad_in[24] = 1'b1;
      tick(4);
      rdchk("R9 level set", 8'hC4, 32'h01);
      wr(8'hC4, 32'h01);
      rdchk("R9 clear blocked", 8'hC4, 32'h01);
      @(negedge clk) pad_in[24] = 1'b0;
      tick(4);
      rdchk("R9 latched after low", 8'hC4, 32'h01);
      wr(8'hC4, 32'h01);
      rdchk("R9 clear after low", 8'hC4, 32'h00);

      // R10 / R7 interrupt through unmask and mask
      wr(8'hCC, 32'h01);
      chk("R10 unmasked idle", {31'd0, irq}, 32'd0);
      @(negedge clk) pad_in[24] = 1'b1;
      tick(4);
      #2 chk("R10 irq level", {31'd0, irq}, 32'd1);
      rdchk("R8 sec3 masked", 8'hC0, 32'h01);
      wr(8'hC8, 32'h01);
      #2 chk("R7 mask gates irq", {31'd0, irq}, 32'd0);
      rdchk("R8 masked after mask", 8'hC0, 32'h00);

      // R8 write to masked status ignored
      @(negedge clk) pad_in[0] = 1'b1;
      tick(4);
      wr(8'h00, 32'hFF);
      rdchk("R8 write ignored", 8'h04, 32'h01);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule